// File: doc/BRIEF.md
# Link Rate and Lane Selector

This block chooses how a serial display link should be configured for a given payload data rate. It holds a short fixed list of per-lane rates, 270000 and then 162000, ordered from fast to slow. It takes the lower of what the sink reports and what the source allows as the ceiling on rate and lane count. From these it offers one configuration to an external training engine. The selection uses the fewest lanes that can carry the payload at the current rate, and then the slowest rate that still carries it on that lane count.

The training engine answers with a pass or fail pulse. On a pass the configuration is held until the next request. On a fail the block moves one entry down the rate list, starts the lane search again from the maximum lane count, and offers again. When the list runs out it reports that it is exhausted. For every offer the block also builds the source-side link control word and the two configuration bytes to be written to the sink.

Top module: `link_cfg_selector`

## Requirements
- R1: After reset `cfg_valid` and `exhausted` are 0, and `sel_rate`, `sel_lanes`, `src_ctrl`, `sink_bw_byte` and `sink_lane_byte` are all 0.
- R2: The required rate is `floor(payload_rate/8)*10`. For example, payload 431999 gives 539990 and selects 270000 on 2 lanes, while payload 432000 gives 540000 and selects 162000 on 4 lanes.
- R3: The maximum rate is the smaller of `sink_rate_cap*27000` and `src_max_rate`. The search starts at the first list entry (270000, then 162000) that does not exceed it. If no entry qualifies, `exhausted` goes to 1 and no configuration is offered.
- R4: The maximum lane count is the smaller of `sink_lane_cap[4:0]` and `src_max_lanes`; bits 7:5 of `sink_lane_cap` are ignored. Starting from the maximum, the lane count is halved (integer shift) for as long as half the lanes at the current rate still exceed the required rate. A maximum lane count of 0 gives `exhausted`.
- R5: With the lane count fixed, the block moves to the next lower list rate for as long as that rate times the lane count still exceeds the required rate.
- R6: A failing `train_done` pulse during an offer moves the search to the next list entry below the offered rate and redoes R4 and R5 from the maximum lane count. Past the last entry, `cfg_valid` goes to 0 and `exhausted` goes to 1, and `exhausted` stays set until the next `start`.
- R7: A passing `train_done` pulse keeps `cfg_valid` at 1 and holds every configuration output unchanged until the next `start`, whatever the other inputs do.
- R8: `src_ctrl` holds the lane count in bits 7:0 and the rate code `sel_rate/27000` in bits 13:8 (10 for 270000, 6 for 162000). Bit 14 is set when `enh_cap` was 1 at `start`, and bit 15 is 0.
- R9: `sink_bw_byte` is the rate code. `sink_lane_byte` holds the lane count in bits 4:0 and has bit 7 set when `enh_cap` was 1 at `start`.
- R10: The block samples its inputs on the clock edge that sees `start`, and `start` restarts it from any state. The outcome (`cfg_valid` or `exhausted`) appears on the second rising edge after that edge's cycle begins, that is, two edges after `start` is driven. A `train_done` pulse that arrives while no offer stands has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new selection; samples all capability inputs |
| payload_rate | input | PAY_W | Required payload data rate |
| sink_rate_cap | input | 8 | Sink maximum rate code (multiple of 27000) |
| sink_lane_cap | input | 8 | Sink lane capability; lane count in bits 4:0 |
| src_max_rate | input | RATE_W | Source maximum per-lane rate |
| src_max_lanes | input | LANE_W | Source maximum lane count |
| enh_cap | input | 1 | Sink supports enhanced framing |
| train_done | input | 1 | One-cycle training result strobe |
| train_pass | input | 1 | Training result, valid with train_done |
| cfg_valid | output | 1 | A configuration is offered or has been accepted |
| exhausted | output | 1 | No rate left to try |
| sel_rate | output | RATE_W | Selected per-lane rate |
| sel_lanes | output | LANE_W | Selected lane count |
| src_ctrl | output | 16 | Source link control word |
| sink_bw_byte | output | 8 | Sink rate code byte |
| sink_lane_byte | output | 8 | Sink lane count byte with framing flag |

## Verification
The assertions assume that `train_done` is only meaningful as a single-cycle strobe with `train_pass` steady beside it. They also assume that `start` and `train_done` do not arrive in the same cycle; where both do, `start` wins and the properties exclude that case. The stimulus drives all inputs on falling edges, keeps `start` and `train_done` one cycle wide, and never raises both together. The capability values it applies stay inside the widths above, and the rates it applies are ones the block can both select and encode.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    localparam int RATE_W    = 20;
    localparam int LANE_W    = 5;
    localparam int NUM_RATES = 2;
    localparam int IDX_W     = $clog2(NUM_RATES + 2);
    localparam int REQ_W     = 40;
    localparam int UNIT      = 27000;
    localparam int CTRL_W    = 16;
    localparam int ENH_CTRL_BIT = 14;
    localparam int ENH_SINK_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PICK, ST_OFFER, ST_DONE, ST_EXH
    } state_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [LANE_W-1:0] lanes;
    } pick_t;

    // descending per-lane rate list; any index past the end reads as zero
    function automatic logic [RATE_W-1:0] rate_of(input logic [IDX_W-1:0] i);
        case (i)
            IDX_W'(0): rate_of = RATE_W'(270000);
            IDX_W'(1): rate_of = RATE_W'(162000);
            default:   rate_of = '0;
        endcase
    endfunction

    // rate divided by UNIT, as a lookup instead of a divider
    function automatic logic [7:0] code_of(input logic [IDX_W-1:0] i);
        case (i)
            IDX_W'(0): code_of = 8'd10;
            IDX_W'(1): code_of = 8'd6;
            default:   code_of = 8'd0;
        endcase
    endfunction
endpackage

// File: rtl/lrs_cap_merge.sv
module lrs_cap_merge
    import lrs_pkg::*;
(
    input  logic [7:0]        sink_rate_cap,
    input  logic [7:0]        sink_lane_cap,
    input  logic [RATE_W-1:0] src_max_rate,
    input  logic [LANE_W-1:0] src_max_lanes,
    output logic [LANE_W-1:0] max_lanes,
    output logic [IDX_W-1:0]  first_idx
);
    localparam int WIDE_W = RATE_W + 8;

    logic [WIDE_W-1:0] sink_rate;
    logic [RATE_W-1:0] max_rate;
    logic [LANE_W-1:0] sink_lanes;

    always_comb begin
        sink_rate  = WIDE_W'(sink_rate_cap) * WIDE_W'(UNIT);
        max_rate   = (sink_rate < WIDE_W'(src_max_rate)) ? sink_rate[RATE_W-1:0] : src_max_rate;
        sink_lanes = LANE_W'(sink_lane_cap[4:0]);
        max_lanes  = (sink_lanes < src_max_lanes) ? sink_lanes : src_max_lanes;
    end

    // first list entry not above the ceiling; the terminator if none fits
    always_comb begin
        logic found;
        found     = 1'b0;
        first_idx = IDX_W'(NUM_RATES);
        for (int k = 0; k < NUM_RATES; k++) begin
            if (!found && rate_of(IDX_W'(k)) <= max_rate) begin
                found     = 1'b1;
                first_idx = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/lrs_pick.sv
module lrs_pick
    import lrs_pkg::*;
(
    input  logic [REQ_W-1:0]  req_rate,
    input  logic [LANE_W-1:0] max_lanes,
    input  logic [IDX_W-1:0]  idx_in,
    output pick_t             pick
);
    always_comb begin
        logic [LANE_W-1:0] ln;
        logic [IDX_W-1:0]  ix;
        ln = max_lanes;
        for (int k = 0; k < LANE_W; k++) begin
            if (REQ_W'(ln >> 1) * REQ_W'(rate_of(idx_in)) > req_rate)
                ln = ln >> 1;
        end
        ix = idx_in;
        for (int k = 0; k < NUM_RATES; k++) begin
            if (REQ_W'(rate_of(ix + 1'b1)) * REQ_W'(ln) > req_rate)
                ix = ix + 1'b1;
        end
        pick.idx   = ix;
        pick.lanes = ln;
    end
endmodule

// File: rtl/lrs_words.sv
module lrs_words
    import lrs_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] lanes,
    input  logic              enh,
    output logic [RATE_W-1:0] rate,
    output logic [CTRL_W-1:0] ctrl,
    output logic [7:0]        bw_byte,
    output logic [7:0]        lane_byte
);
    always_comb begin
        rate      = rate_of(idx);
        bw_byte   = code_of(idx);
        ctrl      = (CTRL_W'(bw_byte) << 8) | CTRL_W'(lanes);
        ctrl[ENH_CTRL_BIT] = enh;
        lane_byte = 8'(lanes);
        lane_byte[ENH_SINK_BIT] = enh;
    end
endmodule

// File: rtl/link_cfg_selector.sv
module link_cfg_selector
    import lrs_pkg::*;
#(
    parameter int PAY_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [PAY_W-1:0]     payload_rate,
    input  logic [7:0]           sink_rate_cap,
    input  logic [7:0]           sink_lane_cap,
    input  logic [RATE_W-1:0]    src_max_rate,
    input  logic [LANE_W-1:0]    src_max_lanes,
    input  logic                 enh_cap,
    input  logic                 train_done,
    input  logic                 train_pass,
    output logic                 cfg_valid,
    output logic                 exhausted,
    output logic [RATE_W-1:0]    sel_rate,
    output logic [LANE_W-1:0]    sel_lanes,
    output logic [CTRL_W-1:0]    src_ctrl,
    output logic [7:0]           sink_bw_byte,
    output logic [7:0]           sink_lane_byte
);
    state_e            state;
    logic [REQ_W-1:0]  req_q;
    logic [LANE_W-1:0] max_lanes_q;
    logic              enh_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  sel_idx_q;
    logic [LANE_W-1:0] sel_lanes_q;

    logic [LANE_W-1:0] cap_lanes;
    logic [IDX_W-1:0]  first_idx;
    pick_t             pick;

    lrs_cap_merge u_merge (
        .sink_rate_cap (sink_rate_cap),
        .sink_lane_cap (sink_lane_cap),
        .src_max_rate  (src_max_rate),
        .src_max_lanes (src_max_lanes),
        .max_lanes     (cap_lanes),
        .first_idx     (first_idx)
    );

    lrs_pick u_pick (
        .req_rate  (req_q),
        .max_lanes (max_lanes_q),
        .idx_in    (idx_q),
        .pick      (pick)
    );

    lrs_words u_words (
        .idx       (sel_idx_q),
        .lanes     (sel_lanes_q),
        .enh       (enh_q),
        .rate      (sel_rate),
        .ctrl      (src_ctrl),
        .bw_byte   (sink_bw_byte),
        .lane_byte (sink_lane_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            req_q       <= '0;
            max_lanes_q <= '0;
            enh_q       <= 1'b0;
            idx_q       <= IDX_W'(NUM_RATES);
            sel_idx_q   <= IDX_W'(NUM_RATES);
            sel_lanes_q <= '0;
        end else if (start) begin
            req_q       <= REQ_W'(payload_rate >> 3) * REQ_W'(10);
            max_lanes_q <= cap_lanes;
            enh_q       <= enh_cap;
            idx_q       <= first_idx;
            state       <= ST_PICK;
        end else begin
            case (state)
                ST_PICK: begin
                    if (rate_of(idx_q) == '0 || max_lanes_q == '0) begin
                        state <= ST_EXH;
                    end else begin
                        sel_idx_q   <= pick.idx;
                        sel_lanes_q <= pick.lanes;
                        state       <= ST_OFFER;
                    end
                end
                ST_OFFER: begin
                    if (train_done) begin
                        if (train_pass) begin
                            state <= ST_DONE;
                        end else begin
                            idx_q <= sel_idx_q + 1'b1;
                            state <= ST_PICK;
                        end
                    end
                end
                default: state <= state;
            endcase
        end
    end

    assign cfg_valid = (state == ST_OFFER) || (state == ST_DONE);
    assign exhausted = (state == ST_EXH);
    assign sel_lanes = sel_lanes_q;

    // R6: a failed offer goes back to picking, one list entry lower
    assert_fallback_step_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFFER && train_done && !train_pass && !start)
        |=> (state == ST_PICK && idx_q == IDX_W'($past(sel_idx_q) + 1'b1)));

    // R6: exhaustion is held until a new request
    assert_exhaust_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (exhausted && !start) |=> exhausted);

    // R7: an accepted configuration stays put
    assert_hold_after_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !start)
        |=> (state == ST_DONE && $stable(sel_idx_q) && $stable(sel_lanes_q)));

    // R4: an offer never uses zero lanes or more than the merged maximum
    assert_lanes_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> (sel_lanes != '0 && sel_lanes <= max_lanes_q));

    // R3: an offer always carries a list rate
    assert_rate_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> (sel_rate != '0));
endmodule

// File: tb/test_link_cfg_selector.sv
module test_link_cfg_selector;
    import lrs_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0]       pay;
        logic [7:0]        scap;
        logic [7:0]        lcap;
        logic [RATE_W-1:0] smax;
        logic [LANE_W-1:0] slanes;
        logic              enh;
        logic              exh;
        logic [RATE_W-1:0] rate;
        logic [LANE_W-1:0] lanes;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'd800000,  8'd10, 8'h04, 20'd270000, 5'd4, 1'b1, 1'b0, 20'd270000, 5'd4}, // R5 no drop
        '{32'd400000,  8'd10, 8'h04, 20'd270000, 5'd4, 1'b0, 1'b0, 20'd270000, 5'd2}, // R4 halve once
        '{32'd200000,  8'd10, 8'h04, 20'd270000, 5'd4, 1'b1, 1'b0, 20'd270000, 5'd1}, // R4 halve twice
        '{32'd100000,  8'd10, 8'h04, 20'd270000, 5'd4, 1'b0, 1'b0, 20'd162000, 5'd1}, // R5 drop rate
        '{32'd1000000, 8'd10, 8'h04, 20'd270000, 5'd4, 1'b1, 1'b0, 20'd270000, 5'd4}, // R5 oversize
        '{32'd400000,  8'd6,  8'h04, 20'd270000, 5'd4, 1'b0, 1'b0, 20'd162000, 5'd4}, // R3 sink ceiling
        '{32'd400000,  8'd10, 8'hE2, 20'd270000, 5'd4, 1'b1, 1'b0, 20'd270000, 5'd2}, // R4 mask
        '{32'd400000,  8'd5,  8'h04, 20'd270000, 5'd4, 1'b0, 1'b1, 20'd0,      5'd0}, // R3 none fits
        '{32'd100000,  8'd10, 8'h04, 20'd200000, 5'd4, 1'b0, 1'b0, 20'd162000, 5'd1}, // R3 source ceiling
        '{32'd7,       8'd10, 8'h04, 20'd270000, 5'd4, 1'b0, 1'b0, 20'd162000, 5'd1}, // R2 tiny
        '{32'd431999,  8'd10, 8'h04, 20'd270000, 5'd4, 1'b0, 1'b0, 20'd270000, 5'd2}, // R2 below edge
        '{32'd432000,  8'd10, 8'h04, 20'd270000, 5'd4, 1'b0, 1'b0, 20'd162000, 5'd4}, // R2 at edge
        '{32'd400000,  8'd10, 8'h04, 20'd270000, 5'd2, 1'b1, 1'b0, 20'd270000, 5'd2}, // R4 source lanes
        '{32'd400000,  8'd10, 8'h00, 20'd270000, 5'd4, 1'b0, 1'b1, 20'd0,      5'd0}  // R4 zero lanes
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [31:0]       payload_rate;
    logic [7:0]        sink_rate_cap;
    logic [7:0]        sink_lane_cap;
    logic [RATE_W-1:0] src_max_rate;
    logic [LANE_W-1:0] src_max_lanes;
    logic              enh_cap;
    logic              train_done;
    logic              train_pass;
    logic              cfg_valid;
    logic              exhausted;
    logic [RATE_W-1:0] sel_rate;
    logic [LANE_W-1:0] sel_lanes;
    logic [CTRL_W-1:0] src_ctrl;
    logic [7:0]        sink_bw_byte;
    logic [7:0]        sink_lane_byte;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_cfg_selector i_link_cfg_selector (
        .clk, .rst, .start, .payload_rate, .sink_rate_cap, .sink_lane_cap,
        .src_max_rate, .src_max_lanes, .enh_cap, .train_done, .train_pass,
        .cfg_valid, .exhausted, .sel_rate, .sel_lanes, .src_ctrl,
        .sink_bw_byte, .sink_lane_byte
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected words straight from R8 and R9
    task automatic chk_words(input string tag, input logic [RATE_W-1:0] r,
                             input logic [LANE_W-1:0] l, input logic e);
        logic [7:0]  code;
        logic [15:0] ctrl;
        logic [7:0]  lb;
        code = 8'(r / 27000);
        ctrl = {1'b0, e, code[5:0], 3'b000, l};
        lb   = {e, 2'b00, l};
        chk({tag, " R8 src_ctrl"}, 64'(src_ctrl), 64'(ctrl));
        chk({tag, " R9 sink bytes"}, {48'd0, sink_bw_byte, sink_lane_byte}, {48'd0, code, lb});
    endtask

    task automatic apply(input vec_t v);
        payload_rate  = v.pay;
        sink_rate_cap = v.scap;
        sink_lane_cap = v.lcap;
        src_max_rate  = v.smax;
        src_max_lanes = v.slanes;
        enh_cap       = v.enh;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic train(input logic pass);
        train_done = 1'b1;
        train_pass = pass;
        @(negedge clk);
        train_done = 1'b0;
        train_pass = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog expired, all requirements");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; train_done = 1'b0; train_pass = 1'b0;
        payload_rate = '0; sink_rate_cap = '0; sink_lane_cap = '0;
        src_max_rate = '0; src_max_lanes = '0; enh_cap = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", {cfg_valid, exhausted}, 2'b00);
        chk("R1 outputs", {sel_rate, sel_lanes, src_ctrl, sink_bw_byte, sink_lane_byte}, '0);

        // table walk: R2 R3 R4 R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            chk($sformatf("vec%0d R3 status", i), {cfg_valid, exhausted}, {~VECS[i].exh, VECS[i].exh});
            if (!VECS[i].exh) begin
                chk($sformatf("vec%0d R4 R5 config", i), {sel_rate, sel_lanes}, {VECS[i].rate, VECS[i].lanes});
                chk_words($sformatf("vec%0d", i), VECS[i].rate, VECS[i].lanes, VECS[i].enh);
                train(1'b1);
            end
        end

        // R10 latency: nothing after one edge, offer after two
        payload_rate = 32'd400000; sink_rate_cap = 8'd10; sink_lane_cap = 8'h04;
        src_max_rate = 20'd270000; src_max_lanes = 5'd4; enh_cap = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 no offer after one edge", {cfg_valid, exhausted}, 2'b00);
        @(negedge clk);
        chk("R10 offer after two edges", {cfg_valid, exhausted}, 2'b10);

        // R6 fallback from 270000x2 at required 500000: lanes restart at 4
        train(1'b0);
        chk("R6 gap during re-pick", 64'(cfg_valid), 64'd0);
        @(negedge clk);
        chk("R6 fallback config", {cfg_valid, sel_rate, sel_lanes}, {1'b1, 20'd162000, 5'd4});
        chk_words("R6 fallback", 20'd162000, 5'd4, 1'b0);
        train(1'b0);
        @(negedge clk);
        chk("R6 exhausted after last rate", {cfg_valid, exhausted}, 2'b01);
        // R10 a stray result while nothing is offered is ignored
        train(1'b1);
        repeat (2) @(negedge clk);
        chk("R10 stray result ignored", {cfg_valid, exhausted}, 2'b01);

        // R6 fallback from 270000x4 at required 1000000
        apply(VECS[0]);
        train(1'b0);
        @(negedge clk);
        chk("R6 fallback from full width", {cfg_valid, sel_rate, sel_lanes}, {1'b1, 20'd162000, 5'd4});

        // R10 restart during an offer
        apply(VECS[2]);
        chk("R10 restart re-picks", {cfg_valid, sel_rate, sel_lanes}, {1'b1, 20'd270000, 5'd1});

        // R7 hold after pass while inputs move and a fail strobe arrives
        train(1'b1);
        payload_rate = 32'd5; sink_rate_cap = 8'd1; src_max_lanes = 5'd1; enh_cap = 1'b0;
        train(1'b0);
        repeat (3) @(negedge clk);
        chk("R7 hold valid", {cfg_valid, exhausted, sel_rate, sel_lanes}, {2'b10, 20'd270000, 5'd1});
        chk_words("R7 hold", 20'd270000, 5'd1, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule